// File: doc/BRIEF.md
# Blocking Counting Semaphore Cell

This block is one counting semaphore shared by several requesters over a single access port. Each access carries a view code, a read strobe, a write strobe, the requester number and a data word. The view code decides how the access is interpreted. A read through one of the two take views performs a P: it returns the count and lowers it by one if it was positive. A write through either take view performs a V: it raises the count, stopping at 0xFFFF, and releases every requester that is waiting. A bypass view observes the count without touching it, and a control view reads and loads three tag flags.

A blocking P that finds the count at zero raises `stall` in the same cycle and records the requester in an internal wait set. The next V pulses `wake` with the whole wait set for one cycle and empties the set. A woken requester re-issues its P, and it succeeds only if the count is then nonzero. A try P on zero never stalls. A build parameter marks the cell as a FIFO cell. In that build every take-view access returns zero and has no effect.

Top module: `sem_cell`

## Requirements
- R1: A read with view 2 (blocking take) or view 3 (try take) puts the count held before the access on `rdata` in the next cycle, and lowers the count by one when that count was above zero. `rdata` changes only after a read strobe and holds its value otherwise.
- R2: A blocking take read (view 2) on a zero count drives `stall` high in the same cycle, leaves the count at zero and adds bit `req_id` to the wait set.
- R3: A try take read (view 3) on a zero count returns 0, does not stall and leaves both the count and the wait set unchanged.
- R4: A write with view 2 or 3 raises the count by one only when it is below 0xFFFF. The count never wraps, and the value on `wdata` is ignored.
- R5: In the cycle after such a write, `wake` carries the wait set, one bit per requester number, and the set is emptied. `wake` is zero in every other cycle.
- R6: When the read and write strobes are both high on a take view, the read sees the count held before the access and the increment is applied after the decrement. A requester that stalls in that cycle is included in the `wake` pulse it causes.
- R7: A bypass read (view 0) returns the count without changing it. A bypass write is ignored.
- R8: A control read (view 1) returns a word with flag T at bit 16, F at bit 1, E at bit 0, the FIFO flag at bit 17 (0 for a semaphore cell) and zeros elsewhere. A control write loads T, F and E from the same bit positions of `wdata`.
- R9: In a cell built as a FIFO cell, take-view reads return 0 and take-view accesses never change the count, never stall and never wake. Its control read shows bit 17 set.
- R10: After reset the count is 0, all tag flags are clear, the wait set is empty, and `rdata`, `wake` and `stall` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_view | input | 2 | View code: 0 bypass, 1 control, 2 blocking take, 3 try take |
| rd_stb | input | 1 | Read strobe for this cycle's access |
| wr_stb | input | 1 | Write strobe for this cycle's access |
| req_id | input | ID_W (3) | Number of the accessing requester |
| wdata | input | DATA_W (32) | Write data; only control writes use it |
| rdata | output | DATA_W (32) | Registered read result, valid the cycle after a read |
| stall | output | 1 | Blocking take on zero count in the current cycle |
| wake | output | N_REQ (8) | One-cycle release pulse, one bit per requester |

## Verification
A take and a release can land in the same cycle when both strobes are raised together on a take view. The case that matters is a blocking take on a zero count paired with a release. The stalling requester has to appear in the very wake pulse that the release produces. Otherwise it would sleep through the only wakeup. The bench provokes this with a waiter already parked, and then again at a count of one and at the 0xFFFF ceiling. In each case it compares the stall, the pulse, the returned value and the follow-up count against its cycle-level model.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;

    typedef enum logic [1:0] {
        VW_BYPASS = 2'd0,
        VW_CTRL   = 2'd1,
        VW_PBLK   = 2'd2,
        VW_PTRY   = 2'd3
    } view_e;

    localparam int TAG_E_BIT    = 0;
    localparam int TAG_F_BIT    = 1;
    localparam int TAG_T_BIT    = 16;
    localparam int TAG_FIFO_BIT = 17;

    typedef struct packed {
        logic t;
        logic f;
        logic e;
    } tag_t;

endpackage

// File: rtl/sem_count_unit.sv
module sem_count_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             give_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] after_take;

    always_comb begin
        st_d       = st_q;
        after_take = st_q.cnt;
        if (take_i && st_q.cnt != '0) begin
            after_take = st_q.cnt - 1'b1;
        end
        st_d.cnt = after_take;
        if (give_i && after_take != CNT_MAX) begin
            st_d.cnt = after_take + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/sem_wait_tracker.sv
module sem_wait_tracker #(
    parameter int N_REQ = 8,
    parameter int ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park_i,
    input  logic [ID_W-1:0]  park_id_i,
    input  logic             release_i,
    output logic [N_REQ-1:0] mask_o,
    output logic [N_REQ-1:0] wake_o
);
    typedef struct packed {
        logic [N_REQ-1:0] mask;
        logic [N_REQ-1:0] wake;
    } wait_state_t;

    wait_state_t      st_d, st_q;
    logic [N_REQ-1:0] park_vec;

    always_comb begin
        park_vec = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (park_i && int'(park_id_i) == i) begin
                park_vec[i] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (release_i) begin
            st_d.wake = st_q.mask | park_vec;
            st_d.mask = '0;
        end else begin
            st_d.wake = '0;
            st_d.mask = st_q.mask | park_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign wake_o = st_q.wake;

endmodule

// File: rtl/sem_tag_reg.sv
module sem_tag_reg
    import sem_cell_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] wdata_i,
    output tag_t              tag_o
);
    typedef struct packed {
        tag_t tag;
    } tag_state_t;

    tag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.tag.t = wdata_i[TAG_T_BIT];
            st_d.tag.f = wdata_i[TAG_F_BIT];
            st_d.tag.e = wdata_i[TAG_E_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tag_o = st_q.tag;

endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_cell_pkg::*;
#(
    parameter int N_REQ   = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter bit IS_FIFO = 1'b0,
    localparam int ID_W   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        acc_view,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ID_W-1:0]   req_id,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              stall,
    output logic [N_REQ-1:0]  wake
);
    view_e vw;
    logic  sem_on;
    logic  is_take_view;
    logic  take_req;
    logic  give_req;
    logic  starve;
    logic  tag_load;

    logic [CNT_W-1:0] cnt_w;
    logic [N_REQ-1:0] mask_w;
    tag_t             tag_w;
    logic [DATA_W-1:0] tag_word;

    assign vw = view_e'(acc_view);

    generate
        if (IS_FIFO) begin : g_fifo_cell
            assign sem_on = 1'b0;
        end else begin : g_sem_cell
            assign sem_on = 1'b1;
        end
    endgenerate

    assign is_take_view = (vw == VW_PBLK) || (vw == VW_PTRY);
    assign take_req     = rd_stb && is_take_view && sem_on;
    assign give_req     = wr_stb && is_take_view && sem_on;
    assign starve       = take_req && (vw == VW_PBLK) && (cnt_w == '0);
    assign tag_load     = wr_stb && (vw == VW_CTRL);

    sem_count_unit #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (take_req),
        .give_i (give_req),
        .cnt_o  (cnt_w)
    );

    sem_wait_tracker #(
        .N_REQ (N_REQ),
        .ID_W  (ID_W)
    ) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .park_i    (starve),
        .park_id_i (req_id),
        .release_i (give_req),
        .mask_o    (mask_w),
        .wake_o    (wake)
    );

    sem_tag_reg #(
        .DATA_W (DATA_W)
    ) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tag_load),
        .wdata_i (wdata),
        .tag_o   (tag_w)
    );

    always_comb begin
        tag_word               = '0;
        tag_word[TAG_T_BIT]    = tag_w.t;
        tag_word[TAG_F_BIT]    = tag_w.f;
        tag_word[TAG_E_BIT]    = tag_w.e;
        tag_word[TAG_FIFO_BIT] = IS_FIFO;
    end

    typedef struct packed {
        logic [DATA_W-1:0] rd;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_stb) begin
            unique case (vw)
                VW_BYPASS: rd_d.rd = DATA_W'(cnt_w);
                VW_CTRL:   rd_d.rd = tag_word;
                default:   rd_d.rd = sem_on ? DATA_W'(cnt_w) : '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.rd;
    assign stall = starve;

endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
    parameter int N_REQ   = 8,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter bit IS_FIFO = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        acc_view,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [DATA_W-1:0] rdata,
    input logic              stall,
    input logic [N_REQ-1:0]  wake,
    input logic [CNT_W-1:0]  cnt_w,
    input logic [N_REQ-1:0]  mask_w
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic take_view;
    assign take_view = acc_view[1];

    p_read_old_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && take_view && !IS_FIFO) |=> (rdata[CNT_W-1:0] == $past(cnt_w)));

    p_take_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb && take_view && cnt_w != '0 && !IS_FIFO)
        |=> (cnt_w == $past(cnt_w) - 1'b1));

    p_stall_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (cnt_w == '0 && rd_stb && acc_view == 2'd2));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && take_view && cnt_w == CNT_MAX) |=> (cnt_w == CNT_MAX));

    p_wake_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake != '0) |-> $past(wr_stb && take_view));

    p_mask_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && take_view && !IS_FIFO) |=> (mask_w == '0));

    p_bypass_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && rd_stb && acc_view == 2'd0) |=> $stable(cnt_w));

    p_fifo_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        IS_FIFO |-> (cnt_w == '0 && wake == '0 && !stall));

endmodule

bind sem_cell sem_cell_chk #(
    .N_REQ   (N_REQ),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .IS_FIFO (IS_FIFO)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_view (acc_view),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .rdata    (rdata),
    .stall    (stall),
    .wake     (wake),
    .cnt_w    (cnt_w),
    .mask_w   (mask_w)
);

// File: tb/tb_sem_cell.sv
`timescale 1ns/1ps
module tb_sem_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_view = 2'd0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0;
    logic [2:0]  req_id = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        stall;
    logic [7:0]  wake;

    logic [1:0]  f_view = 2'd0;
    logic        f_rd = 1'b0, f_wr = 1'b0;
    logic [31:0] f_rdata;
    logic        f_stall;
    logic [7:0]  f_wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_cnt = 0, m_mask = 0, m_wake = 0, m_rd = 0;
    int m_t = 0, m_f = 0, m_e = 0;

    always #4 clk = ~clk;

    sem_cell dut (
        .clk(clk), .rst_n(rst_n), .acc_view(acc_view), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .req_id(req_id), .wdata(wdata), .rdata(rdata),
        .stall(stall), .wake(wake)
    );

    sem_cell #(.IS_FIFO(1'b1)) dut_f (
        .clk(clk), .rst_n(rst_n), .acc_view(f_view), .rd_stb(f_rd),
        .wr_stb(f_wr), .req_id(3'd4), .wdata(32'h0001_0003), .rdata(f_rdata),
        .stall(f_stall), .wake(f_wake)
    );

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    function automatic int tag_word();
        return (m_t << 16) | (m_f << 1) | m_e;
    endfunction

    // One access cycle; entered and left at a falling edge.
    task automatic cyc(input bit r, input bit w, input int v, input int id,
                       input int d, input string req);
        int  old;
        bit  pv;
        bit  park;
        int  pbit;
        rd_stb = r; wr_stb = w; acc_view = v[1:0]; req_id = id[2:0]; wdata = d;
        pv   = (v >= 2);
        park = r && (v == 2) && (m_cnt == 0);
        pbit = park ? (1 << id) : 0;
        #1;
        chk(req, "stall", stall, park);
        @(posedge clk);
        old = m_cnt;
        if (r) begin
            if (v == 1) m_rd = tag_word();
            else        m_rd = old;
        end
        if (r && pv && m_cnt > 0) m_cnt = m_cnt - 1;
        if (w && pv) begin
            if (m_cnt < 65535) m_cnt = m_cnt + 1;
            m_wake = m_mask | pbit;
            m_mask = 0;
        end else begin
            m_wake = 0;
            m_mask = m_mask | pbit;
        end
        if (w && v == 1) begin
            m_t = (d >> 16) & 1; m_f = (d >> 1) & 1; m_e = d & 1;
        end
        @(negedge clk);
        chk(req, "rdata", rdata, m_rd);
        chk(req, "wake", wake, m_wake);
    endtask

    task automatic fcyc(input bit r, input bit w, input int v, input string req,
                        input longint exp_rd);
        f_rd = r; f_wr = w; f_view = v[1:0];
        #1;
        chk(req, "fifo stall", f_stall, 0);
        @(posedge clk);
        @(negedge clk);
        chk(req, "fifo rdata", f_rdata, exp_rd);
        chk(req, "fifo wake", f_wake, 0);
        f_rd = 1'b0; f_wr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "rdata", rdata, 0);
        chk("R10", "wake", wake, 0);
        chk("R10", "stall", stall, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(1, 0, 1, 0, 0, "R10");          // tags clear
        cyc(1, 0, 0, 0, 0, "R10");          // count zero
        // R3 try take on zero
        cyc(1, 0, 3, 1, 0, "R3");
        // R2 blocking takes park requesters 3 and 5
        cyc(1, 0, 2, 3, 0, "R2");
        cyc(1, 0, 2, 5, 0, "R2");
        cyc(1, 0, 3, 1, 0, "R3");           // must not join the wait set
        cyc(0, 0, 0, 0, 0, "R1");           // rdata holds
        // R4/R5 release with junk data, wake = 0x28
        cyc(0, 1, 2, 0, 32'hDEAD_BEEF, "R5");
        cyc(0, 0, 0, 0, 0, "R5");           // pulse lasts one cycle
        // R1 take returns pre-access count
        cyc(1, 0, 3, 3, 0, "R1");
        cyc(1, 0, 0, 0, 0, "R1");
        cyc(0, 1, 3, 0, 7, "R4");
        cyc(0, 1, 2, 0, 9, "R4");
        // R7 bypass
        cyc(1, 0, 0, 0, 0, "R7");
        cyc(0, 1, 0, 0, 32'h77, "R7");
        cyc(1, 0, 0, 0, 0, "R7");
        cyc(1, 0, 2, 6, 0, "R1");
        cyc(1, 0, 2, 6, 0, "R1");
        // R8 control view
        cyc(0, 1, 1, 0, 32'h0001_0003, "R8");
        cyc(1, 0, 1, 0, 0, "R8");
        cyc(1, 1, 1, 0, 32'h0000_0002, "R8");
        cyc(1, 0, 1, 0, 0, "R8");
        // R6 take and release together; requester 6 already parked
        cyc(1, 0, 2, 6, 0, "R6");
        cyc(1, 1, 2, 2, 0, "R6");           // wake 0x44, count 1
        cyc(1, 1, 3, 0, 0, "R6");           // returns 1, count stays 1
        cyc(1, 0, 0, 0, 0, "R6");
        cyc(1, 0, 3, 2, 0, "R1");           // woken requester re-issues
        cyc(1, 0, 2, 0, 0, "R2");           // next one parks again
        // R4 saturation
        for (int i = 0; i < 65538; i++) cyc(0, 1, 3, 0, i, "R4");
        cyc(1, 0, 0, 0, 0, "R4");
        cyc(1, 1, 2, 1, 0, "R6");
        cyc(1, 0, 0, 0, 0, "R4");
        cyc(1, 0, 3, 1, 0, "R1");
        rd_stb = 1'b0; wr_stb = 1'b0;
        // R9 FIFO-configured cell
        fcyc(0, 1, 2, "R9", 0);
        fcyc(1, 0, 2, "R9", 0);
        fcyc(1, 0, 3, "R9", 0);
        fcyc(1, 0, 0, "R9", 0);
        fcyc(1, 0, 1, "R9", 32'h0002_0000);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule